// File: doc/BRIEF.md
# Multiplexed Pixel Stream Frame Assembler

This block turns the digitized output of a column-parallel sensor readout back into image rows. The sensor's columns are split among readout modules. Each module holds one row of samples, then sends them out one at a time through a MUX:1 selector into a converter running at MUX times the row rate. Every converter sample strobe therefore carries one sample from every module lane, all at the same selector slot. A per-strobe flag tells whether that strobe carries real charge readout. Strobes taken while the sensor clocks are paused are not flagged, and neither are strobes in the period that directly follows a frame start, because the converted data trail the sensor by one row period.

The assembler writes each flagged sample into a two-row, per-module banked buffer. The column position is lane × MUX + slot. At the next row boundary it decides whether the period just finished held a complete row. A complete row is streamed out one pixel per clock, with start-of-row and end-of-frame markers and its row number. A period that is only partly flagged is dropped and marks the frame as faulty. At each frame start, the frame that just closed is judged: the error output is raised if its count of complete rows differs from the frame height. Because rows are emitted one row period late, the last row of a frame needs one more row boundary (a flush period) before the next frame start. One instance serves one side of a sensor that is read out from two opposite edges. A parameter mirrors the column order for the side whose columns run the other way.

Top module: `pfa_frame_assembler`

## Requirements
- R1: After reset, pix_valid, pix_sor, pix_eof and frame_err are all low.
- R2: A flagged sample on lane m (bits m*16+15..m*16 of smp_data) at slot s is output as the pixel in column m*MUX+s. Slot 0 is the strobe that has row_start high, and each later strobe in the period adds one to the slot.
- R3: A row period with no flagged strobe emits no pixel and does not count as a row.
- R4: A row period whose MUX slots are all flagged is emitted after the next row_start strobe. It appears as COLS pixels on consecutive clocks, columns 0 to COLS-1 in ascending order.
- R5: pix_sor is high exactly on the column-0 pixel of each emitted row.
- R6: Rows are emitted only after a frame_start. pix_row is the index of the complete row within the frame, counting from 0. Complete rows beyond ROWS are not emitted.
- R7: pix_eof is high only on the column COLS-1 pixel of row ROWS-1.
- R8: A row period with between 1 and MUX-1 flagged strobes emits nothing, does not count as a row, and marks the frame as faulty.
- R9: On each frame_start, frame_err is set to 1 if the closing frame had a partial period or a complete-row count other than ROWS, and to 0 otherwise. On the first frame_start after reset it is set to 0. It holds its value between frame starts.
- R10: With REVERSE set, output column c carries the sample that would be placed in column COLS-1-c when REVERSE is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Closes the current frame and opens a new one; never together with smp_stb |
| row_start | input | 1 | Marks the strobe that is slot 0 of a row period |
| smp_stb | input | 1 | One converter sample per lane is present |
| smp_flag | input | 1 | Sample strobe carries charge readout |
| smp_data | input | LANES*16 | One 16-bit sample per module lane, lane 0 in the low bits |
| pix_valid | output | 1 | Pixel output valid |
| pix_data | output | 16 | Pixel value |
| pix_col | output | clog2(LANES*MUX) | Column of the pixel |
| pix_row | output | clog2(ROWS) | Row of the pixel in the frame |
| pix_sor | output | 1 | Start of row marker |
| pix_eof | output | 1 | End of frame marker |
| frame_err | output | 1 | Closed frame had a wrong row count or a partial period |

## Verification
The bench builds two instances with 4 lanes, a 4-way selector and a 6-row frame, one in natural column order and one mirrored. Both receive identical stimulus, so every frame closes within a few hundred clocks. Frames that come up short, frames that run long, partial periods and frame-end markers can all be reached many times. The small sizes also let the full 16-pixel row readout fit into a 20-clock row period, so consecutive rows stream back to back.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
  localparam int PIX_W = 16;
  typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/pfa_bank_ram.sv
module pfa_bank_ram
  import pfa_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  pix_t          wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output pix_t          rdata
);
  pix_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pfa_capture.sv
module pfa_capture #(
  parameter int MUX  = 16,
  parameter int ROWS = 256,
  localparam int SW = $clog2(MUX),
  localparam int AW = SW + 1,
  localparam int KW = $clog2(MUX + 1),
  localparam int RW = $clog2(ROWS),
  localparam int NW = $clog2(ROWS + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          row_start,
  input  logic          smp_stb,
  input  logic          smp_flag,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          launch,
  output logic          launch_half,
  output logic [RW-1:0] launch_row,
  output logic          frame_err
);
  logic [KW-1:0] slot_q, cnt_q, slot;
  logic [NW-1:0] rows_q;
  logic          half_q, open_q, part_q;
  logic          in_range, boundary, full, launch_c, half_eff;

  // slot of the current strobe; a row_start strobe is slot 0
  always_comb begin
    slot     = row_start ? '0 : slot_q;
    in_range = slot < KW'(MUX);
    boundary = smp_stb && row_start && !frame_start;
    full     = cnt_q == KW'(MUX);
    launch_c = boundary && full && open_q && (rows_q < NW'(ROWS));
    half_eff = launch_c ? ~half_q : half_q;
    wr_en    = smp_stb && !frame_start && smp_flag && in_range;
    wr_addr  = {half_eff, slot[SW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q      <= '0;
      cnt_q       <= '0;
      rows_q      <= '0;
      half_q      <= 1'b0;
      open_q      <= 1'b0;
      part_q      <= 1'b0;
      frame_err   <= 1'b0;
      launch      <= 1'b0;
      launch_half <= 1'b0;
      launch_row  <= '0;
    end else if (frame_start) begin
      frame_err <= open_q && (part_q || rows_q != NW'(ROWS));
      open_q    <= 1'b1;
      rows_q    <= '0;
      part_q    <= 1'b0;
      cnt_q     <= '0;
      slot_q    <= '0;
      launch    <= 1'b0;
    end else begin
      launch <= launch_c;
      if (launch_c) begin
        half_q      <= ~half_q;
        launch_half <= half_q;
        launch_row  <= RW'(rows_q);
      end
      if (boundary && open_q) begin
        if (full) begin
          if (rows_q != NW'(ROWS + 1)) rows_q <= rows_q + 1'b1;
        end else if (cnt_q != '0) begin
          part_q <= 1'b1;
        end
      end
      if (smp_stb) begin
        slot_q <= in_range ? slot + 1'b1 : slot;
        cnt_q  <= (row_start ? '0 : cnt_q) + KW'(smp_flag && in_range);
      end
    end
  end
endmodule

// File: rtl/pfa_readout.sv
module pfa_readout
  import pfa_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int MUX     = 16,
  parameter int ROWS    = 256,
  parameter bit REVERSE = 1'b0,
  localparam int COLS = LANES * MUX,
  localparam int SW   = $clog2(MUX),
  localparam int CW   = $clog2(COLS),
  localparam int LW   = CW - SW,
  localparam int AW   = SW + 1,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  launch,
  input  logic                  launch_half,
  input  logic [RW-1:0]         launch_row,
  input  logic [LANES-1:0][PIX_W-1:0] bank_q,
  output logic                  rd_en,
  output logic [AW-1:0]         rd_addr,
  output logic                  pix_valid,
  output pix_t                  pix_data,
  output logic [CW-1:0]         pix_col,
  output logic [RW-1:0]         pix_row,
  output logic                  pix_sor,
  output logic                  pix_eof
);
  localparam logic [CW-1:0] LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] LROW = RW'(ROWS - 1);

  logic          active_q, half_q;
  logic [CW-1:0] col_q, idx;
  logic [RW-1:0] row_q;
  logic          p1_valid;
  logic [CW-1:0] p1_col;
  logic [RW-1:0] p1_row;
  logic [LW-1:0] p1_bank;

  // storage column for the output column, per side orientation
  generate
    if (REVERSE) begin : g_mirror
      assign idx = LAST - col_q;
    end else begin : g_direct
      assign idx = col_q;
    end
  endgenerate

  assign rd_en   = active_q;
  assign rd_addr = {half_q, idx[SW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      half_q    <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
      p1_valid  <= 1'b0;
      p1_col    <= '0;
      p1_row    <= '0;
      p1_bank   <= '0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_col   <= '0;
      pix_row   <= '0;
      pix_sor   <= 1'b0;
      pix_eof   <= 1'b0;
    end else begin
      if (launch) begin
        active_q <= 1'b1;
        col_q    <= '0;
        half_q   <= launch_half;
        row_q    <= launch_row;
      end else if (active_q) begin
        col_q <= col_q + 1'b1;
        if (col_q == LAST) active_q <= 1'b0;
      end
      p1_valid  <= active_q;
      p1_col    <= col_q;
      p1_row    <= row_q;
      p1_bank   <= idx[CW-1:SW];
      pix_valid <= p1_valid;
      pix_data  <= bank_q[p1_bank];
      pix_col   <= p1_col;
      pix_row   <= p1_row;
      pix_sor   <= p1_valid && (p1_col == '0);
      pix_eof   <= p1_valid && (p1_col == LAST) && (p1_row == LROW);
    end
  end
endmodule

// File: rtl/pfa_frame_assembler.sv
module pfa_frame_assembler
  import pfa_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int MUX     = 16,
  parameter int ROWS    = 256,
  parameter bit REVERSE = 1'b0,
  localparam int COLS = LANES * MUX,
  localparam int SW   = $clog2(MUX),
  localparam int AW   = SW + 1,
  localparam int CW   = $clog2(COLS),
  localparam int RW   = $clog2(ROWS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic                   row_start,
  input  logic                   smp_stb,
  input  logic                   smp_flag,
  input  logic [LANES*PIX_W-1:0] smp_data,
  output logic                   pix_valid,
  output logic [PIX_W-1:0]       pix_data,
  output logic [CW-1:0]          pix_col,
  output logic [RW-1:0]          pix_row,
  output logic                   pix_sor,
  output logic                   pix_eof,
  output logic                   frame_err
);
  logic          wr_en, rd_en, launch, launch_half;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [RW-1:0] launch_row;
  logic [LANES-1:0][PIX_W-1:0] bank_q;

  pfa_capture #(.MUX(MUX), .ROWS(ROWS)) u_cap (
    .clk(clk), .rst(rst), .frame_start(frame_start), .row_start(row_start),
    .smp_stb(smp_stb), .smp_flag(smp_flag), .wr_en(wr_en), .wr_addr(wr_addr),
    .launch(launch), .launch_half(launch_half), .launch_row(launch_row),
    .frame_err(frame_err)
  );

  // one two-row bank per module lane
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_bank
      pfa_bank_ram #(.DEPTH(2 * MUX)) u_ram (
        .clk(clk), .we(wr_en), .waddr(wr_addr),
        .wdata(smp_data[g*PIX_W +: PIX_W]),
        .re(rd_en), .raddr(rd_addr), .rdata(bank_q[g])
      );
    end
  endgenerate

  pfa_readout #(.LANES(LANES), .MUX(MUX), .ROWS(ROWS), .REVERSE(REVERSE)) u_rd (
    .clk(clk), .rst(rst), .launch(launch), .launch_half(launch_half),
    .launch_row(launch_row), .bank_q(bank_q), .rd_en(rd_en), .rd_addr(rd_addr),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_col(pix_col),
    .pix_row(pix_row), .pix_sor(pix_sor), .pix_eof(pix_eof)
  );
endmodule

// File: rtl/pfa_chk.sv
module pfa_chk #(
  parameter int COLS = 256,
  parameter int ROWS = 256,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic          pix_valid,
  input logic [CW-1:0] pix_col,
  input logic [RW-1:0] pix_row,
  input logic          pix_sor,
  input logic          pix_eof,
  input logic          frame_err
);
  localparam logic [CW-1:0] LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] LROW = RW'(ROWS - 1);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pix_valid && !frame_err));

  // R5
  sor_col_chk: assert property (@(posedge clk) disable iff (rst)
    pix_sor |-> (pix_valid && pix_col == '0));

  // R7
  eof_pos_chk: assert property (@(posedge clk) disable iff (rst)
    pix_eof |-> (pix_valid && pix_col == LAST && pix_row == LROW));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_col != LAST) |=> (pix_valid && pix_col == CW'($past(pix_col) + 1'b1)));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(frame_err));
endmodule

bind pfa_frame_assembler pfa_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .pix_valid(pix_valid),
  .pix_col(pix_col), .pix_row(pix_row), .pix_sor(pix_sor), .pix_eof(pix_eof),
  .frame_err(frame_err)
);

// File: tb/sim_pfa_frame_assembler.sv
`timescale 1ns/1ps
module sim_pfa_frame_assembler;
  localparam int LANES = 4, MUX = 4, ROWS = 6, COLS = LANES * MUX;
  localparam int CW = $clog2(COLS), RW = $clog2(ROWS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, frame_start = 1'b0, row_start = 1'b0, smp_stb = 1'b0, smp_flag = 1'b0;
  logic [LANES*16-1:0] smp_data = '0;
  logic v0, s0, e0, err0, v1, s1, e1, err1;
  logic [15:0] d0, d1;
  logic [CW-1:0] c0, c1;
  logic [RW-1:0] r0, r1;

  pfa_frame_assembler #(.LANES(LANES), .MUX(MUX), .ROWS(ROWS), .REVERSE(1'b0)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .row_start(row_start),
    .smp_stb(smp_stb), .smp_flag(smp_flag), .smp_data(smp_data),
    .pix_valid(v0), .pix_data(d0), .pix_col(c0), .pix_row(r0),
    .pix_sor(s0), .pix_eof(e0), .frame_err(err0));

  pfa_frame_assembler #(.LANES(LANES), .MUX(MUX), .ROWS(ROWS), .REVERSE(1'b1)) u1 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .row_start(row_start),
    .smp_stb(smp_stb), .smp_flag(smp_flag), .smp_data(smp_data),
    .pix_valid(v1), .pix_data(d1), .pix_col(c1), .pix_row(r1),
    .pix_sor(s1), .pix_eof(e1), .frame_err(err1));

  typedef struct packed {
    logic [15:0]   d;
    logic [CW-1:0] c;
    logic [RW-1:0] r;
    logic          e;
  } exp_t;

  exp_t q0[$], q1[$];
  logic [15:0] rowbuf [COLS];
  int checks = 0, fails = 0, rows_m = 0;
  bit open_m = 0, part_m = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // output monitors; the reversed instance checks R10 on data
  always @(negedge clk) begin
    if (!rst) begin
      if (v0) begin
        exp_t x;
        if (q0.size() == 0) check(1'b0, "R6", "unexpected pixel u0 col", int'(c0), -1);
        else begin
          x = q0.pop_front();
          check(d0 == x.d, "R2", "u0 data", int'(d0), int'(x.d));
          check(c0 == x.c, "R4", "u0 col", int'(c0), int'(x.c));
          check(r0 == x.r, "R6", "u0 row", int'(r0), int'(x.r));
          check(s0 == (x.c == 0), "R5", "u0 sor", int'(s0), int'(x.c == 0));
          check(e0 == x.e, "R7", "u0 eof", int'(e0), int'(x.e));
        end
      end
      if (v1) begin
        exp_t y;
        if (q1.size() == 0) check(1'b0, "R10", "unexpected pixel u1 col", int'(c1), -1);
        else begin
          y = q1.pop_front();
          check(d1 == y.d, "R10", "u1 data", int'(d1), int'(y.d));
          check(c1 == y.c, "R4", "u1 col", int'(c1), int'(y.c));
          check(e1 == y.e, "R7", "u1 eof", int'(e1), int'(y.e));
        end
      end
    end
  end

  // one row period; the first nflag slots are flagged (R3 when 0, R8 when partial)
  task automatic period(input int nflag);
    for (int s = 0; s < MUX; s++) begin
      @(negedge clk);
      smp_stb = 1'b1;
      row_start = (s == 0);
      smp_flag = (s < nflag);
      for (int m = 0; m < LANES; m++) begin
        logic [15:0] v;
        v = 16'($urandom);
        smp_data[m*16 +: 16] = v;
        if (s < nflag) rowbuf[m*MUX + s] = v;
      end
      @(negedge clk);
      smp_stb = 1'b0;
      row_start = 1'b0;
      smp_flag = 1'b0;
      repeat (3) @(negedge clk);
    end
    if (open_m && nflag == MUX) begin
      if (rows_m < ROWS) begin
        for (int c = 0; c < COLS; c++) begin
          q0.push_back('{d: rowbuf[c], c: CW'(c), r: RW'(rows_m), e: (rows_m == ROWS - 1) && (c == COLS - 1)});
          q1.push_back('{d: rowbuf[COLS-1-c], c: CW'(c), r: RW'(rows_m), e: (rows_m == ROWS - 1) && (c == COLS - 1)});
        end
      end
      if (rows_m <= ROWS) rows_m++;
    end else if (open_m && nflag > 0 && nflag < MUX) begin
      part_m = 1'b1;
    end
  endtask

  task automatic new_frame();
    bit exp;
    exp = open_m && (part_m || rows_m != ROWS);
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check(err0 == exp, "R9", "u0 frame_err", int'(err0), int'(exp));
    check(err1 == exp, "R9", "u1 frame_err", int'(err1), int'(exp));
    open_m = 1'b1;
    rows_m = 0;
    part_m = 1'b0;
  endtask

  task automatic rows_with_pauses(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom % 3 == 0) period(0);
      period(MUX);
    end
    period(0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4821));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(v0 == 1'b0, "R1", "pix_valid after reset", int'(v0), 0);
    check(s0 == 1'b0 && e0 == 1'b0, "R1", "markers after reset", int'(s0) + int'(e0), 0);
    check(err0 == 1'b0, "R1", "frame_err after reset", int'(err0), 0);

    // full rows with no frame open: nothing out (R6)
    period(MUX);
    period(MUX);
    period(0);
    new_frame();                 // first frame start: R9 expects 0
    period(0);                   // delay period, no flags (R3)
    rows_with_pauses(ROWS);      // good frame
    new_frame();                 // expect 0
    rows_with_pauses(ROWS - 1);  // short frame
    new_frame();                 // expect 1
    period(0);
    rows_with_pauses(3);
    period(1 + int'($urandom % (MUX - 1)));  // partial period (R8)
    rows_with_pauses(3);
    new_frame();                 // expect 1 from partial
    rows_with_pauses(ROWS + 1);  // long frame, extra row dropped
    new_frame();                 // expect 1
    rows_with_pauses(ROWS);
    new_frame();                 // expect 0

    repeat (40) @(negedge clk);
    check(q0.size() == 0, "R4", "pending pixels u0", q0.size(), 0);
    check(q1.size() == 0, "R10", "pending pixels u1", q1.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule